// File: doc/BRIEF.md
# Per-Privilege Capability Mode and Register Access Controller

This block keeps the capability-related enable bits that live inside three configuration registers of a capability-extended RISC-V hart: the machine security configuration word, the machine environment configuration word and the supervisor environment configuration word. The control path reads and writes these words through a simple CSR port. The block holds each word's ordinary (non-capability) fields as plain storage. Positions that are not implemented read as zero.

From the stored bits, the current privilege level, a per-mode "XLEN narrower than XLENMAX" flag and the mode bit of the program counter capability, the block works out two things combinationally. The first is whether the hart executes in Capability or Legacy mode. The second is whether explicit access to capability registers is allowed. When access is not allowed, the block raises an illegal-instruction flag for any capability instruction or capability CSR address presented to it. It also forces Legacy execution, whatever the mode-enable bits hold.

Each privilege level draws on its own enable bits, and the bits are layered. Machine mode takes its mode enable from the security word. Supervisor mode is governed by the machine environment word. User mode is governed by the supervisor environment word. The supervisor register-enable can only be set while the machine register-enable is set.

Top module: `cheri_mode_ctrl`

## Requirements
- R1: After reset, all three configuration words read as zero, so every mode enable and register enable is 0 and machine mode starts in Legacy execution.
- R2: In machine mode (priv 2'b11), the applicable mode enable is bit 3 of the machine security word (select 0). A value of 1 selects Capability execution and 0 selects Legacy execution.
- R3: In supervisor mode (priv 2'b01), the applicable mode enable is bit 28 of the machine environment word (select 1). In user mode (priv 2'b00, and also the reserved encoding 2'b10), it is bit 28 of the supervisor environment word (select 2).
- R4: Register access (`reg_access_en`) is always on in machine mode. In supervisor mode it needs bit 29 of the machine environment word. In user mode it needs bit 29 of the supervisor environment word. In every mode it is off while that mode's narrow-XLEN flag is set (`xlen_narrow` bit 0 for U, bit 1 for S, bit 2 for M).
- R5: Bit 29 of the supervisor environment word reads 0 and ignores writes while bit 29 of the machine environment word is 0. Writing the machine word with bit 29 clear also clears the supervisor bit, so it stays 0 after the machine bit is set again.
- R6: While register access is off, `cap_mode` is 0 regardless of any mode-enable bit.
- R7: `illegal_insn` is 1 exactly when register access is off and `insn_is_cap` or `insn_is_cap_csr` is 1.
- R8: With the mode-switching variant on (MODE_SWITCH=1, the default), `cap_mode` is 1 only if `pcc_mode_bit` is 1 and the applicable mode enable is 1.
- R9: The non-capability fields are plain storage. The machine security word keeps bits 2:0 and 9:8. The machine environment word keeps bits 0, 7:4 and 63:62. The supervisor environment word keeps bits 0 and 7:4. All other positions read 0. Select 3 reads 0, and writes to it change nothing.
- R10: A CSR write becomes visible on the read port and on the derived outputs after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe |
| csr_wr_sel | input | 2 | Write target: 0 machine security, 1 machine environment, 2 supervisor environment |
| csr_wr_data | input | XLEN | Write data |
| csr_rd_sel | input | 2 | Read source, same encoding as the write target |
| csr_rd_data | output | XLEN | Read data of the selected word |
| priv | input | 2 | Current privilege: 00 U, 01 S, 11 M, 10 treated as U |
| xlen_narrow | input | 3 | Per mode, XLEN below XLENMAX: bit 0 U, bit 1 S, bit 2 M |
| pcc_mode_bit | input | 1 | Mode bit of the program counter capability |
| insn_is_cap | input | 1 | Current instruction is a capability instruction |
| insn_is_cap_csr | input | 1 | Current instruction addresses a capability CSR |
| cap_mode | output | 1 | 1 for Capability execution, 0 for Legacy |
| reg_access_en | output | 1 | Explicit capability register access allowed |
| illegal_insn | output | 1 | Illegal-instruction request |

## Verification
The assertions check the relations that hold on every cycle. The stored supervisor register-enable never stays set without the machine one. A blocked supervisor write leaves the bit at zero. Legacy execution and the illegal flag follow from disabled access. A narrow XLEN always removes access, and a clear program-counter mode bit always forces Legacy. A write to the security word lands on the next edge. Only the bench's directed scenarios can show the rest: the exact field positions and selected source for each privilege level, the cascade where clearing the machine enable leaves the supervisor bit cleared after re-enabling, the storage masks of the plain fields, and that nothing changes before the clock edge.

// File: rtl/cheri_mode_pkg.sv
package cheri_mode_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUPV = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    WORD_MSEC = 2'b00,
    WORD_MENV = 2'b01,
    WORD_SENV = 2'b10,
    WORD_NONE = 2'b11
  } word_sel_e;

  typedef struct packed {
    logic mach_mode_en;
    logic menv_mode_en;
    logic menv_reg_en;
    logic senv_mode_en;
    logic senv_reg_en;
  } enable_bits_t;

  // Index into the per-mode narrow flags: 0 user, 1 supervisor, 2 machine.
  function automatic logic [1:0] priv_slot(input logic [1:0] p);
    case (priv_e'(p))
      PRIV_MACH: priv_slot = 2'd2;
      PRIV_SUPV: priv_slot = 2'd1;
      default:   priv_slot = 2'd0;
    endcase
  endfunction

  function automatic logic pick_mode_en(input logic [1:0] p, input enable_bits_t b);
    case (priv_e'(p))
      PRIV_MACH: pick_mode_en = b.mach_mode_en;
      PRIV_SUPV: pick_mode_en = b.menv_mode_en;
      default:   pick_mode_en = b.senv_mode_en;
    endcase
  endfunction

  function automatic logic pick_reg_en(input logic [1:0] p, input enable_bits_t b);
    case (priv_e'(p))
      PRIV_MACH: pick_reg_en = 1'b1;
      PRIV_SUPV: pick_reg_en = b.menv_reg_en;
      default:   pick_reg_en = b.senv_reg_en;
    endcase
  endfunction

  // Build a read word from kept plain bits and one or two enable bits.
  function automatic logic [63:0] place_bit(input logic [63:0] base, input int pos, input logic v);
    logic [63:0] w;
    w = base;
    w[pos] = v;
    place_bit = w;
  endfunction

endpackage

// File: rtl/cheri_cfg_store.sv
module cheri_cfg_store
  import cheri_mode_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter int          SEC_MODE_POS = 3,
  parameter int          ENV_MODE_POS = 28,
  parameter int          ENV_REG_POS  = 29,
  parameter logic [63:0] SEC_KEEP     = 64'h0000_0000_0000_0307,
  parameter logic [63:0] MENV_KEEP    = 64'hC000_0000_0000_00F1,
  parameter logic [63:0] SENV_KEEP    = 64'h0000_0000_0000_00F1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [XLEN-1:0] rd_data,
  output enable_bits_t    bits
);

  localparam logic [XLEN-1:0] SEC_ONE  = XLEN'(1) << SEC_MODE_POS;
  localparam logic [XLEN-1:0] ENV_ONES = (XLEN'(1) << ENV_MODE_POS) | (XLEN'(1) << ENV_REG_POS);
  localparam logic [XLEN-1:0] SEC_MASK  = XLEN'(SEC_KEEP)  & ~SEC_ONE;
  localparam logic [XLEN-1:0] MENV_MASK = XLEN'(MENV_KEEP) & ~ENV_ONES;
  localparam logic [XLEN-1:0] SENV_MASK = XLEN'(SENV_KEEP) & ~ENV_ONES;

  logic [XLEN-1:0] sec_plain, menv_plain, senv_plain;
  logic            sec_mode_q, menv_mode_q, menv_reg_q, senv_mode_q, senv_reg_q;

  // Named events for the checks below.
  logic wr_sec, wr_menv, wr_senv;
  logic senv_reg_blocked;
  logic senv_reg_cascade_clr;

  assign wr_sec  = wr_en && (word_sel_e'(wr_sel) == WORD_MSEC);
  assign wr_menv = wr_en && (word_sel_e'(wr_sel) == WORD_MENV);
  assign wr_senv = wr_en && (word_sel_e'(wr_sel) == WORD_SENV);
  assign senv_reg_blocked     = wr_senv && !menv_reg_q;
  assign senv_reg_cascade_clr = wr_menv && !wr_data[ENV_REG_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_plain   <= '0;
      menv_plain  <= '0;
      senv_plain  <= '0;
      sec_mode_q  <= 1'b0;
      menv_mode_q <= 1'b0;
      menv_reg_q  <= 1'b0;
      senv_mode_q <= 1'b0;
      senv_reg_q  <= 1'b0;
    end else begin
      if (wr_sec) begin
        sec_plain  <= wr_data & SEC_MASK;
        sec_mode_q <= wr_data[SEC_MODE_POS];
      end
      if (wr_menv) begin
        menv_plain  <= wr_data & MENV_MASK;
        menv_mode_q <= wr_data[ENV_MODE_POS];
        menv_reg_q  <= wr_data[ENV_REG_POS];
      end
      if (senv_reg_cascade_clr) begin
        senv_reg_q <= 1'b0;
      end
      if (wr_senv) begin
        senv_plain  <= wr_data & SENV_MASK;
        senv_mode_q <= wr_data[ENV_MODE_POS];
        if (!senv_reg_blocked) begin
          senv_reg_q <= wr_data[ENV_REG_POS];
        end
      end
    end
  end

  logic [XLEN-1:0] sec_word, menv_word, senv_word;

  always_comb begin
    sec_word  = sec_plain;
    sec_word[SEC_MODE_POS] = sec_mode_q;
    menv_word = menv_plain;
    menv_word[ENV_MODE_POS] = menv_mode_q;
    menv_word[ENV_REG_POS]  = menv_reg_q;
    senv_word = senv_plain;
    senv_word[ENV_MODE_POS] = senv_mode_q;
    senv_word[ENV_REG_POS]  = senv_reg_q & menv_reg_q;
  end

  always_comb begin
    case (word_sel_e'(rd_sel))
      WORD_MSEC: rd_data = sec_word;
      WORD_MENV: rd_data = menv_word;
      WORD_SENV: rd_data = senv_word;
      default:   rd_data = '0;
    endcase
  end

  assign bits = '{mach_mode_en: sec_mode_q,
                  menv_mode_en: menv_mode_q,
                  menv_reg_en:  menv_reg_q,
                  senv_mode_en: senv_mode_q,
                  senv_reg_en:  senv_reg_q & menv_reg_q};

  // R5: the supervisor register enable is never held without the machine one.
  assert_senv_needs_menv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    senv_reg_q |-> menv_reg_q);

  // R5: a supervisor write while the machine enable is clear leaves the bit at zero.
  assert_senv_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_senv && !menv_reg_q) |=> !senv_reg_q);

  // R10: a write to the security word shows its mode bit after the next edge.
  assert_sec_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sec |=> (sec_mode_q == $past(wr_data[SEC_MODE_POS])));

endmodule

// File: rtl/cheri_mode_resolve.sv
module cheri_mode_resolve
  import cheri_mode_pkg::*;
#(
  parameter bit MODE_SWITCH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   priv,
  input  logic [2:0]   xlen_narrow,
  input  logic         pcc_mode_bit,
  input  logic         insn_is_cap,
  input  logic         insn_is_cap_csr,
  input  enable_bits_t bits,
  output logic         cap_mode,
  output logic         reg_access_en,
  output logic         illegal_insn
);

  logic [1:0] slot;
  logic       narrow_now;
  logic       level_reg_en;
  logic       level_mode_en;
  logic       pcc_gate;
  logic       cap_request;

  assign slot          = priv_slot(priv);
  assign narrow_now    = xlen_narrow[slot];
  assign level_reg_en  = pick_reg_en(priv, bits);
  assign level_mode_en = pick_mode_en(priv, bits);
  assign cap_request   = insn_is_cap || insn_is_cap_csr;

  generate
    if (MODE_SWITCH) begin : g_pcc_gate
      assign pcc_gate = pcc_mode_bit;
    end else begin : g_no_pcc_gate
      logic unused_pcc;
      assign unused_pcc = pcc_mode_bit;
      assign pcc_gate   = 1'b1;
    end
  endgenerate

  assign reg_access_en = level_reg_en && !narrow_now;
  assign cap_mode      = reg_access_en && level_mode_en && pcc_gate;
  assign illegal_insn  = !reg_access_en && cap_request;

  // R6: disabled access always means Legacy execution.
  assert_legacy_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_access_en |-> !cap_mode);

  // R7: the illegal flag only appears with disabled access and a capability request.
  assert_illegal_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn |-> (!reg_access_en && cap_request));

  // R4: a narrow XLEN for the current mode removes access.
  assert_narrow_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_now |-> !reg_access_en);

  generate
    if (MODE_SWITCH) begin : g_pcc_check
      // R8: a clear program-counter mode bit forces Legacy execution.
      assert_pcc_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pcc_mode_bit |-> !cap_mode);
    end
  endgenerate

endmodule

// File: rtl/cheri_mode_ctrl.sv
module cheri_mode_ctrl
  import cheri_mode_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter bit          MODE_SWITCH  = 1'b1,
  parameter int          SEC_MODE_POS = 3,
  parameter int          ENV_MODE_POS = 28,
  parameter int          ENV_REG_POS  = 29,
  parameter logic [63:0] SEC_KEEP     = 64'h0000_0000_0000_0307,
  parameter logic [63:0] MENV_KEEP    = 64'hC000_0000_0000_00F1,
  parameter logic [63:0] SENV_KEEP    = 64'h0000_0000_0000_00F1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_wr_en,
  input  logic [1:0]      csr_wr_sel,
  input  logic [XLEN-1:0] csr_wr_data,
  input  logic [1:0]      csr_rd_sel,
  output logic [XLEN-1:0] csr_rd_data,
  input  logic [1:0]      priv,
  input  logic [2:0]      xlen_narrow,
  input  logic            pcc_mode_bit,
  input  logic            insn_is_cap,
  input  logic            insn_is_cap_csr,
  output logic            cap_mode,
  output logic            reg_access_en,
  output logic            illegal_insn
);

  enable_bits_t bits;

  cheri_cfg_store #(
    .XLEN         (XLEN),
    .SEC_MODE_POS (SEC_MODE_POS),
    .ENV_MODE_POS (ENV_MODE_POS),
    .ENV_REG_POS  (ENV_REG_POS),
    .SEC_KEEP     (SEC_KEEP),
    .MENV_KEEP    (MENV_KEEP),
    .SENV_KEEP    (SENV_KEEP)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr_en),
    .wr_sel  (csr_wr_sel),
    .wr_data (csr_wr_data),
    .rd_sel  (csr_rd_sel),
    .rd_data (csr_rd_data),
    .bits    (bits)
  );

  cheri_mode_resolve #(
    .MODE_SWITCH (MODE_SWITCH)
  ) resolve_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .priv            (priv),
    .xlen_narrow     (xlen_narrow),
    .pcc_mode_bit    (pcc_mode_bit),
    .insn_is_cap     (insn_is_cap),
    .insn_is_cap_csr (insn_is_cap_csr),
    .bits            (bits),
    .cap_mode        (cap_mode),
    .reg_access_en   (reg_access_en),
    .illegal_insn    (illegal_insn)
  );

endmodule

// File: tb/cheri_mode_ctrl_tb.sv
module cheri_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam logic [63:0] K_SEC  = 64'h0000_0000_0000_0307 | (64'd1 << 3);
  localparam logic [63:0] K_MENV = 64'hC000_0000_0000_00F1 | (64'd3 << 28);
  localparam logic [63:0] K_SENV = 64'h0000_0000_0000_00F1 | (64'd3 << 28);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_wr_en = 1'b0;
  logic [1:0]      csr_wr_sel = 2'd0;
  logic [XLEN-1:0] csr_wr_data = '0;
  logic [1:0]      csr_rd_sel = 2'd0;
  logic [XLEN-1:0] csr_rd_data;
  logic [1:0]      priv = 2'b11;
  logic [2:0]      xlen_narrow = 3'b000;
  logic            pcc_mode_bit = 1'b1;
  logic            insn_is_cap = 1'b0;
  logic            insn_is_cap_csr = 1'b0;
  logic            cap_mode, reg_access_en, illegal_insn;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  logic [63:0] sh_sec, sh_menv, sh_senv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cheri_mode_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .csr_wr_en (csr_wr_en), .csr_wr_sel (csr_wr_sel), .csr_wr_data (csr_wr_data),
    .csr_rd_sel (csr_rd_sel), .csr_rd_data (csr_rd_data),
    .priv (priv), .xlen_narrow (xlen_narrow), .pcc_mode_bit (pcc_mode_bit),
    .insn_is_cap (insn_is_cap), .insn_is_cap_csr (insn_is_cap_csr),
    .cap_mode (cap_mode), .reg_access_en (reg_access_en), .illegal_insn (illegal_insn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Shadow update written from the requirements (R5, R9).
  task automatic shadow_write(input logic [1:0] sel, input logic [63:0] d);
    case (sel)
      2'd0: sh_sec = d & K_SEC;
      2'd1: begin
        sh_menv = d & K_MENV;
        if (!d[29]) sh_senv[29] = 1'b0;
      end
      2'd2: begin
        logic keep_re;
        keep_re = sh_senv[29];
        sh_senv = d & K_SENV;
        if (!sh_menv[29]) sh_senv[29] = keep_re;
      end
      default: ;
    endcase
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wr_data = d;
    @(posedge clk);
    #1;
    csr_wr_en = 1'b0;
    shadow_write(sel, d);
  endtask

  task automatic read_chk(input string req, input logic [1:0] sel, input logic [63:0] exp);
    csr_rd_sel = sel;
    #1;
    chk(req, csr_rd_data, exp);
  endtask

  // Expected outputs restated from R2, R3, R4, R6, R7, R8.
  task automatic out_chk(input string req);
    logic acc, men, cap, ill, nar;
    case (priv)
      2'b11: begin nar = xlen_narrow[2]; acc = 1'b1;       men = sh_sec[3];   end
      2'b01: begin nar = xlen_narrow[1]; acc = sh_menv[29]; men = sh_menv[28]; end
      default: begin nar = xlen_narrow[0]; acc = sh_senv[29]; men = sh_senv[28]; end
    endcase
    acc = acc && !nar;
    cap = acc && men && pcc_mode_bit;
    ill = !acc && (insn_is_cap || insn_is_cap_csr);
    #1;
    chk({req, " reg_access_en"}, 64'(reg_access_en), 64'(acc));
    chk({req, " cap_mode"},      64'(cap_mode),      64'(cap));
    chk({req, " illegal_insn"},  64'(illegal_insn),  64'(ill));
  endtask

  task automatic t_reset();
    read_chk("R1 sec word", 2'd0, 64'd0);
    read_chk("R1 menv word", 2'd1, 64'd0);
    read_chk("R1 senv word", 2'd2, 64'd0);
    priv = 2'b11; pcc_mode_bit = 1'b1; insn_is_cap = 1'b1;
    out_chk("R1 machine after reset");
    chk("R1 legacy after reset", 64'(cap_mode), 64'd0);
    insn_is_cap = 1'b0;
  endtask

  task automatic t_machine_mode();
    priv = 2'b11;
    csr_rd_sel = 2'd0;
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_sel = 2'd0; csr_wr_data = 64'h8;
    #1;
    chk("R10 no change before edge", csr_rd_data, 64'd0);
    chk("R10 mode unchanged before edge", 64'(cap_mode), 64'd0);
    @(posedge clk);
    #1;
    csr_wr_en = 1'b0;
    shadow_write(2'd0, 64'h8);
    read_chk("R10 visible after edge", 2'd0, 64'h8);
    out_chk("R2 machine capability");
    chk("R2 cap_mode set", 64'(cap_mode), 64'd1);
    csr_write(2'd0, 64'h0);
    out_chk("R2 machine legacy");
  endtask

  task automatic t_supervisor();
    priv = 2'b01; pcc_mode_bit = 1'b1;
    csr_write(2'd1, 64'd1 << 28);
    insn_is_cap_csr = 1'b1;
    out_chk("R6 supervisor mode bit without reg enable");
    chk("R7 illegal on cap csr", 64'(illegal_insn), 64'd1);
    insn_is_cap_csr = 1'b0;
    csr_write(2'd1, 64'd3 << 28);
    insn_is_cap = 1'b1;
    out_chk("R3 supervisor capability");
    chk("R7 no illegal when enabled", 64'(illegal_insn), 64'd0);
    insn_is_cap = 1'b0;
    csr_write(2'd0, 64'h8);
    csr_write(2'd1, 64'd1 << 29);
    out_chk("R3 supervisor ignores machine security bit");
  endtask

  task automatic t_user_cascade();
    priv = 2'b00;
    csr_write(2'd1, 64'd0);
    csr_write(2'd2, 64'd3 << 28);
    read_chk("R5 blocked supervisor reg enable", 2'd2, 64'd1 << 28);
    insn_is_cap = 1'b1;
    out_chk("R4 user locked");
    insn_is_cap = 1'b0;
    csr_write(2'd1, 64'd1 << 29);
    csr_write(2'd2, 64'd3 << 28);
    read_chk("R5 supervisor reg enable accepted", 2'd2, 64'd3 << 28);
    out_chk("R3 user capability");
    csr_write(2'd1, 64'd0);
    read_chk("R5 cleared by machine bit", 2'd2, 64'd1 << 28);
    csr_write(2'd1, 64'd1 << 29);
    read_chk("R5 stays clear after re-enable", 2'd2, 64'd1 << 28);
    out_chk("R5 user still locked");
    priv = 2'b10;
    csr_write(2'd2, 64'd3 << 28);
    out_chk("R3 reserved priv acts as user");
  endtask

  task automatic t_narrow();
    csr_write(2'd0, 64'h8);
    csr_write(2'd1, 64'd3 << 28);
    csr_write(2'd2, 64'd3 << 28);
    for (int m = 0; m < 3; m++) begin
      priv = (m == 2) ? 2'b11 : 2'(m);
      xlen_narrow = 3'b001 << m;
      insn_is_cap = 1'b1;
      out_chk("R4 narrow xlen");
      chk("R4 narrow locks", 64'(reg_access_en), 64'd0);
      xlen_narrow = ~(3'b001 << m);
      out_chk("R4 other mode narrow");
    end
    xlen_narrow = 3'b000; insn_is_cap = 1'b0;
  endtask

  task automatic t_pcc();
    priv = 2'b11;
    pcc_mode_bit = 1'b0;
    out_chk("R8 pcc clear");
    chk("R8 legacy with pcc clear", 64'(cap_mode), 64'd0);
    pcc_mode_bit = 1'b1;
    out_chk("R8 pcc set");
  endtask

  task automatic t_storage();
    csr_write(2'd0, '1);
    read_chk("R9 sec storage", 2'd0, sh_sec);
    chk("R9 sec mask", sh_sec, 64'h0000_0000_0000_030F);
    csr_write(2'd1, '1);
    read_chk("R9 menv storage", 2'd1, 64'hC000_0000_3000_00F1);
    csr_write(2'd2, '1);
    read_chk("R9 senv storage", 2'd2, 64'h0000_0000_3000_00F1);
    csr_write(2'd3, '1);
    read_chk("R9 select 3 reads zero", 2'd3, 64'd0);
    read_chk("R9 select 3 write no effect", 2'd0, 64'h0000_0000_0000_030F);
    csr_write(2'd1, 64'h0000_0000_0000_0040);
    read_chk("R9 menv partial", 2'd1, 64'h40);
  endtask

  initial begin
    sh_sec = '0; sh_menv = '0; sh_senv = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_machine_mode();
    t_supervisor();
    t_user_cascade();
    t_narrow();
    t_pcc();
    t_storage();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule